// File: doc/BRIEF.md
# Rotating Complex Integer Multiply-Accumulate

This block treats each 128-bit operand as a vector of packed complex integers and performs one rotated half of a complex multiply per issue, adding the result into an accumulator vector. Each complex value sits in two adjacent elements. The lower-addressed element is the real part and the upper one is the imaginary part. A per-operation size select picks 32-bit elements, which give two complex pairs per vector, or 64-bit elements, which give one pair.

A 2-bit rotation code chooses which half of the first source is used as the multiplier. It also chooses which half of the second source pairs with each accumulator half, and which of the two products is negated. Issuing code 00 and then code 01 with the same sources, and feeding the first result back in as the accumulator, adds the full complex product a·b. All pairs are computed in parallel, and one register stage sits between the inputs and the result.

Top module: `cplx_rot_mac`

## Requirements
- R1: Element packing. `in_esz`=0 selects 32-bit elements: pair p uses bits [64p+31:64p] for the real part and [64p+63:64p+32] for the imaginary part, with p = 0 and 1. `in_esz`=1 selects 64-bit elements: bits [63:0] hold the real part and [127:64] the imaginary part.
- R2: With `in_rot`=2'b00, each pair updates as re += a_re·b_re and im += a_re·b_im.
- R3: With `in_rot`=2'b01, each pair updates as re += −(a_im·b_im) and im += a_im·b_re.
- R4: With `in_rot`=2'b10, each pair updates as re += −(a_re·b_re) and im += −(a_re·b_im).
- R5: With `in_rot`=2'b11, each pair updates as re += a_im·b_im and im += −(a_im·b_re).
- R6: Products, negations and sums are all taken modulo 2^W, where W is the element width. There is no saturation, and negating the most negative value wraps back to itself.
- R7: `out_valid` is high in the cycle after `in_valid` was sampled high, and low in the cycle after `in_valid` was sampled low.
- R8: `out_acc` keeps its value across any cycle in which `in_valid` is low.
- R9: A synchronous active-high `rst` clears both `out_valid` and `out_acc` to zero.
- R10: In 32-bit mode the two pairs are independent. The result of a pair depends only on that pair's bits of the three vectors.
- R11: Issuing code 00 and then code 01, with the first result fed back as the accumulator, yields acc + a·b as a full complex product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| in_esz | input | 1 | Element size: 0 = 32-bit, 1 = 64-bit |
| in_rot | input | 2 | Rotation code |
| in_a | input | 128 | First source vector |
| in_b | input | 128 | Second source vector |
| in_acc | input | 128 | Accumulator vector |
| out_valid | output | 1 | Result valid |
| out_acc | output | 128 | Updated accumulator |

## Verification
Each result is due exactly one rising edge after its operands are sampled. The bench drives operands on a falling edge and reads `out_valid` and `out_acc` at the next falling edge, which is half a cycle after the register updates. To check holding, the bench waits one more edge with `in_valid` low and compares the output against the value it just read. Expected vectors come from a separate arithmetic model of the four rotation formulas, computed per element width. The model is applied over a grid of small signed values, wrap-around corners, and a feedback sequence built from two chained issues.

// File: rtl/cplx_rot_mac.sv
module cplx_rot_mac #(
  parameter int VW = 128
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          in_esz,
  input  logic [1:0]    in_rot,
  input  logic [VW-1:0] in_a,
  input  logic [VW-1:0] in_b,
  input  logic [VW-1:0] in_acc,
  output logic          out_valid,
  output logic [VW-1:0] out_acc
);

  logic [VW-1:0] res [2];

  wire use_im  = in_rot[0];
  wire neg_re  = in_rot[0] ^ in_rot[1];
  wire neg_im  = in_rot[1];

  for (genvar s = 0; s < 2; s++) begin : g_size
    localparam int W  = 32 << s;
    localparam int NP = VW / (2 * W);
    for (genvar p = 0; p < NP; p++) begin : g_pair
      localparam int LO = p * 2 * W;
      localparam int HI = LO + W;
      logic [W-1:0] are, aim, bre, bim, m, pre, pim;
      assign are = in_a[LO +: W];
      assign aim = in_a[HI +: W];
      assign bre = in_b[LO +: W];
      assign bim = in_b[HI +: W];
      assign m   = use_im ? aim : are;
      assign pre = m * (use_im ? bim : bre);
      assign pim = m * (use_im ? bre : bim);
      assign res[s][LO +: W] = in_acc[LO +: W] + (neg_re ? -pre : pre);
      assign res[s][HI +: W] = in_acc[HI +: W] + (neg_im ? -pim : pim);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_acc   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_acc <= res[in_esz];
    end
  end

  // R7: valid follows the strobe by one cycle
  p_valid_lat_r7: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_idle_lat_r7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R8: no strobe, no change
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_acc));
  // R2: zero multiplier source leaves the accumulator untouched
  p_zero_src_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_a == '0) |=> (out_acc == $past(in_acc)));
  // R9: reset empties the output
  always_ff @(posedge clk) begin
    if (!rst && $past(rst)) begin
      p_reset_r9: assert (!out_valid || $past(in_valid));
    end
  end

endmodule

// File: tb/test_cplx_rot_mac.sv
module test_cplx_rot_mac;
  logic clk = 0, rst = 1, in_valid = 0, in_esz = 0;
  logic [1:0] in_rot = 0;
  logic [127:0] in_a = 0, in_b = 0, in_acc = 0;
  logic out_valid;
  logic [127:0] out_acc;
  int checks = 0, fails = 0;
  bit done = 0;
  logic [63:0] seed = 64'h9E3779B97F4A7C15;

  always #4 clk = ~clk;

  cplx_rot_mac i_cplx_rot_mac (.clk, .rst, .in_valid, .in_esz, .in_rot,
    .in_a, .in_b, .in_acc, .out_valid, .out_acc);

  function automatic logic [63:0] rnd();
    seed ^= seed << 13; seed ^= seed >> 7; seed ^= seed << 17;
    return seed;
  endfunction

  function automatic string rtag(logic [1:0] r);
    case (r)
      2'b00: return "R2";
      2'b01: return "R3";
      2'b10: return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic logic [63:0] wr(logic [63:0] v, bit w64);
    return w64 ? v : {32'd0, v[31:0]};
  endfunction

  function automatic logic [127:0] model(bit w64, logic [1:0] r,
      logic [127:0] a, logic [127:0] b, logic [127:0] c);
    logic [127:0] o = '0;
    int w = w64 ? 64 : 32;
    int np = w64 ? 1 : 2;
    for (int p = 0; p < np; p++) begin
      logic [63:0] ar, ai, br, bi, cr, ci, dr, di;
      ar = wr(a >> (p*2*w), w64); ai = wr(a >> (p*2*w + w), w64);
      br = wr(b >> (p*2*w), w64); bi = wr(b >> (p*2*w + w), w64);
      cr = wr(c >> (p*2*w), w64); ci = wr(c >> (p*2*w + w), w64);
      case (r)
        2'b00: begin dr = cr + ar*br;    di = ci + ar*bi;    end
        2'b01: begin dr = cr - ai*bi;    di = ci + ai*br;    end
        2'b10: begin dr = cr - ar*br;    di = ci - ar*bi;    end
        default: begin dr = cr + ai*bi;  di = ci - ai*br;    end
      endcase
      o |= {64'd0, wr(dr, w64)} << (p*2*w);
      o |= {64'd0, wr(di, w64)} << (p*2*w + w);
    end
    return o;
  endfunction

  task automatic chk(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic issue(bit w64, logic [1:0] r, logic [127:0] a,
      logic [127:0] b, logic [127:0] c, string tag, output logic [127:0] got);
    logic [127:0] e;
    e = model(w64, r, a, b, c);
    in_esz = w64; in_rot = r; in_a = a; in_b = b; in_acc = c; in_valid = 1;
    @(posedge clk); @(negedge clk);
    in_valid = 0;
    chk(out_valid === 1'b1, "R7 valid", {127'd0, out_valid}, 128'd1);
    chk(out_acc === e, tag, out_acc, e);
    got = out_acc;
  endtask

  function automatic logic [31:0] sm(int v); return 32'(v); endfunction

  initial begin
    #(8*200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [127:0] g, h;
    @(negedge clk); @(negedge clk);
    in_a = '1; in_b = '1; in_acc = '1; in_valid = 1;
    @(negedge clk);
    chk(out_valid === 0 && out_acc === '0, "R9 reset", out_acc, '0);
    rst = 0; in_valid = 0;
    @(negedge clk);
    chk(out_valid === 0, "R7 idle", {127'd0, out_valid}, 0);

    // R1/R2..R5/R10: 32-bit grid on pair 0, random pair 1
    for (int rr = 0; rr < 4; rr++)
      for (int x = -2; x <= 2; x++)
        for (int y = -2; y <= 2; y++)
          for (int z = -2; z <= 2; z++)
            for (int q = -2; q <= 2; q++) begin
              logic [127:0] a, b, c;
              a = {rnd(), sm(y), sm(x)};
              b = {rnd(), sm(q), sm(z)};
              c = {rnd(), rnd()};
              issue(0, 2'(rr), a, b, c, {rtag(2'(rr)), " R1 R10 w32"}, g);
            end

    // 64-bit grid
    for (int rr = 0; rr < 4; rr++)
      for (int k = 0; k < 200; k++) begin
        logic [127:0] a, b, c;
        a = {64'(signed'(k%5-2)) , 64'(signed'(k/5%5-2))};
        b = {rnd(), rnd()};
        c = {rnd(), rnd()};
        issue(1, 2'(rr), a, b, c, {rtag(2'(rr)), " R1 w64"}, g);
      end

    // R8: hold with idle cycle and changing inputs
    in_a = {rnd(), rnd()}; in_acc = {rnd(), rnd()};
    @(posedge clk); @(negedge clk);
    chk(out_acc === g && out_valid === 0, "R8 hold", out_acc, g);

    // R6: wraparound corners
    for (int rr = 0; rr < 4; rr++) begin
      issue(0, 2'(rr), {64'd0, 32'h80000000, 32'h80000000},
            {64'd0, 32'hFFFFFFFF, 32'hFFFFFFFF}, '0, {rtag(2'(rr)), " R6 w32"}, g);
      issue(1, 2'(rr), {64'h8000000000000000, 64'h8000000000000000},
            {64'hFFFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFFFF},
            {64'h7FFFFFFFFFFFFFFF, 64'h7FFFFFFFFFFFFFFF}, {rtag(2'(rr)), " R6 w64"}, g);
    end
    issue(0, 2'b10, {96'd0, 32'h80000000}, {96'd0, 32'd1}, '0, "R6 negmin", g);
    chk(g[31:0] === 32'h80000000, "R6 negmin value", {96'd0, g[31:0]}, {96'd0, 32'h80000000});

    // R11: two issues form full complex multiply
    for (int k = 0; k < 50; k++) begin
      logic [127:0] a, b, c, e;
      a = {rnd(), rnd()}; b = {rnd(), rnd()}; c = {rnd(), rnd()};
      issue(1, 2'b00, a, b, c, "R2 step", g);
      issue(1, 2'b01, a, b, g, "R3 step", h);
      e[63:0]   = c[63:0]   + a[63:0]*b[63:0] - a[127:64]*b[127:64];
      e[127:64] = c[127:64] + a[63:0]*b[127:64] + a[127:64]*b[63:0];
      chk(h === e, "R11 full product", h, e);
    end

    rst = 1; @(negedge clk); rst = 0;
    chk(out_valid === 0 && out_acc === '0, "R9 reset mid", out_acc, '0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule